// File: doc/BRIEF.md
# Packed Float-to-Unsigned-Quadword Truncating Converter

This block turns up to eight IEEE-754 single-precision values into 64-bit unsigned integers. Each conversion rounds toward zero. The operands are vectors that have already been fetched. A vector-length select sets how many lanes are live: 2, 4 or 8, for a 128-, 256- or 512-bit destination. Lane j reads source element j, and each 64-bit result goes to destination slot j.

A per-lane write mask can be enabled. When it is, each lane whose mask bit is clear either keeps its previous destination value (merging) or is cleared (zeroing). A broadcast option feeds source element 0 to every lane. Destination bits above the selected vector length are always cleared.

Two flags report the results of live, unmasked lanes. The invalid flag marks an input that has no 64-bit unsigned value; such a lane returns all ones. The inexact flag marks a discarded fraction. Both flags stay set until reset. The new destination and the flags are captured in registers on a valid strobe.

Top module: `f2u_vec`

## Requirements
- R1: `vl_sel` encoding: 0 gives 2 live lanes, 1 gives 4, and 2 or 3 gives 8. Live lane j writes `dst_o[64j+63:64j]` from `src_i[32j+31:32j]`.
- R2: A positive finite input below 2^64 converts to its integer part, rounded toward zero. Examples: 2.5 gives 2, and 2^63 gives 0x8000000000000000. The inexact flag is set when a nonzero fraction was discarded.
- R3: Certain inputs produce 0xFFFFFFFFFFFFFFFF in their lane and set the invalid flag, but not the inexact flag. These inputs are NaN, +infinity, -infinity, any value of 2^64 or more, and any value of -1.0 or below.
- R4: An input in (-1.0, 0) converts to 0 and sets only the inexact flag. +0 and -0 convert to 0 with no flag. A denormal converts to 0 and sets the inexact flag.
- R5: With `kmask_en_i`=1 and `zero_mode_i`=0, a live lane whose `kmask_i` bit is 0 keeps its `old_dst_i` value.
- R6: With `kmask_en_i`=1 and `zero_mode_i`=1, a live lane whose `kmask_i` bit is 0 becomes 0.
- R7: With `kmask_en_i`=0, every live lane takes its converted value, whatever `kmask_i` holds.
- R8: With `bcast_i`=1, every live lane converts `src_i[31:0]`.
- R9: Every destination bit above the selected vector length becomes 0, whatever the inputs.
- R10: A flag can be set only by a lane that is both live and written. Once set, the flags stay set until reset.
- R11: `dst_o`, the flags and `out_valid_o` update on the clock edge where `in_valid_i` is 1. With `in_valid_i` at 0, `dst_o` holds its value and `out_valid_o` is 0.
- R12: After a synchronous reset, `dst_o`, both flags and `out_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Perform one conversion this cycle |
| src_i | input | 256 | Eight packed single-precision elements |
| bcast_i | input | 1 | Feed element 0 to all lanes |
| vl_sel_i | input | 2 | Vector length: 0=128, 1=256, 2/3=512 |
| kmask_en_i | input | 1 | Enable the per-lane write mask |
| kmask_i | input | 8 | Per-lane write mask |
| zero_mode_i | input | 1 | 1 = zero masked lanes, 0 = merge |
| old_dst_i | input | 512 | Prior destination value, used for merging |
| dst_o | output | 512 | Registered new destination |
| flag_inv_o | output | 1 | Sticky invalid flag |
| flag_inx_o | output | 1 | Sticky inexact flag |
| out_valid_o | output | 1 | High one cycle after a conversion |

## Verification
Several properties are checked by assertions on every cycle:
- merged lanes hold the old destination slot;
- zeroed lanes and lanes beyond the vector length read 0;
- the destination is stable between strobes;
- the flags never fall while reset is low.

Other behaviour is shown only by the directed scenarios:
- the numeric mapping itself, including truncation of fractions and the exact 2^63 boundary;
- the all-ones result for each invalid class;
- the flag effects of denormals and small negatives;
- the suppression of flags from masked or inactive lanes.

// File: rtl/f2u_pkg.sv
package f2u_pkg;
  localparam int FP_W   = 32;
  localparam int MANT_W = 23;
  localparam int EXP_W  = 8;
  localparam int INT_W  = 64;
  localparam int SIG_W  = MANT_W + 1;
  localparam int BIAS   = 127;

  // exponent at which the significand's LSB weighs 1
  localparam logic [EXP_W-1:0] UNIT_EXP = EXP_W'(BIAS + MANT_W);
  // smallest exponent whose value is at least 2^INT_W
  localparam logic [EXP_W-1:0] OVF_EXP  = EXP_W'(BIAS + INT_W);
  localparam logic [EXP_W-1:0] ONE_EXP  = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] SPEC_EXP = '1;

  typedef struct packed {
    logic [INT_W-1:0] val;
    logic             inv;
    logic             inx;
  } lane_res_t;
endpackage

// File: rtl/f2u_lane_cvt.sv
module f2u_lane_cvt
  import f2u_pkg::*;
(
  input  logic [FP_W-1:0] fp_i,
  output lane_res_t       res_o
);
  localparam int RSH_W = $clog2(SIG_W);

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [MANT_W-1:0] fr;
  logic [SIG_W-1:0]  sig;
  logic [EXP_W-1:0]  lsh;
  logic [EXP_W-1:0]  rsh;
  logic [SIG_W-1:0]  lost_mask;

  always_comb begin
    sgn       = fp_i[FP_W-1];
    ex        = fp_i[FP_W-2 -: EXP_W];
    fr        = fp_i[MANT_W-1:0];
    sig       = {1'b1, fr};
    res_o     = '0;
    lsh       = '0;
    rsh       = '0;
    lost_mask = '0;
    if (ex == SPEC_EXP) begin
      res_o.val = '1;
      res_o.inv = 1'b1;
    end else if (ex == '0) begin
      res_o.inx = |fr;
    end else if (sgn) begin
      if (ex >= ONE_EXP) begin
        res_o.val = '1;
        res_o.inv = 1'b1;
      end else begin
        res_o.inx = 1'b1;
      end
    end else if (ex >= OVF_EXP) begin
      res_o.val = '1;
      res_o.inv = 1'b1;
    end else if (ex >= UNIT_EXP) begin
      lsh       = ex - UNIT_EXP;
      res_o.val = INT_W'(sig) << lsh;
    end else begin
      rsh = UNIT_EXP - ex;
      if (rsh >= EXP_W'(SIG_W)) begin
        res_o.inx = 1'b1;
      end else begin
        res_o.val = INT_W'(sig >> rsh[RSH_W-1:0]);
        lost_mask = (SIG_W'(1) << rsh[RSH_W-1:0]) - SIG_W'(1);
        res_o.inx = |(sig & lost_mask);
      end
    end
  end
endmodule

// File: rtl/f2u_vl_decode.sv
module f2u_vl_decode #(
  parameter int LANES = 8,
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] vl_sel_i,
  output logic [LANES-1:0] active_o
);
  localparam int SPAN_W = $clog2(LANES) + 3;
  logic [SPAN_W-1:0] span;

  assign span = SPAN_W'(2) << vl_sel_i;

  for (genvar j = 0; j < LANES; j++) begin : g_act
    assign active_o[j] = (SPAN_W'(j) < span);
  end
endmodule

// File: rtl/f2u_lane_gate.sv
module f2u_lane_gate #(
  parameter int W = 64
) (
  input  logic         active_i,
  input  logic         write_i,
  input  logic         zero_mode_i,
  input  logic [W-1:0] conv_i,
  input  logic [W-1:0] old_i,
  output logic [W-1:0] val_o,
  output logic         flag_en_o
);
  always_comb begin
    if (!active_i)        val_o = '0;
    else if (write_i)     val_o = conv_i;
    else if (zero_mode_i) val_o = '0;
    else                  val_o = old_i;
  end
  assign flag_en_o = active_i & write_i;
endmodule

// File: rtl/f2u_vec.sv
module f2u_vec
  import f2u_pkg::*;
#(
  parameter int LANES = 8,
  parameter int SEL_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid_i,
  input  logic [LANES*FP_W-1:0]  src_i,
  input  logic                   bcast_i,
  input  logic [SEL_W-1:0]       vl_sel_i,
  input  logic                   kmask_en_i,
  input  logic [LANES-1:0]       kmask_i,
  input  logic                   zero_mode_i,
  input  logic [LANES*INT_W-1:0] old_dst_i,
  output logic [LANES*INT_W-1:0] dst_o,
  output logic                   flag_inv_o,
  output logic                   flag_inx_o,
  output logic                   out_valid_o
);
  logic [LANES-1:0]       active;
  logic [LANES-1:0]       flag_en;
  logic [LANES-1:0]       lane_inv;
  logic [LANES-1:0]       lane_inx;
  logic [LANES*INT_W-1:0] next_dst;

  f2u_vl_decode #(.LANES(LANES), .SEL_W(SEL_W)) u_vl (
    .vl_sel_i (vl_sel_i),
    .active_o (active)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [FP_W-1:0] fp_in;
    lane_res_t       res;

    assign fp_in = bcast_i ? src_i[FP_W-1:0] : src_i[j*FP_W +: FP_W];

    f2u_lane_cvt u_cvt (
      .fp_i  (fp_in),
      .res_o (res)
    );

    f2u_lane_gate #(.W(INT_W)) u_gate (
      .active_i    (active[j]),
      .write_i     (~kmask_en_i | kmask_i[j]),
      .zero_mode_i (zero_mode_i),
      .conv_i      (res.val),
      .old_i       (old_dst_i[j*INT_W +: INT_W]),
      .val_o       (next_dst[j*INT_W +: INT_W]),
      .flag_en_o   (flag_en[j])
    );

    assign lane_inv[j] = res.inv & flag_en[j];
    assign lane_inx[j] = res.inx & flag_en[j];

    // R5: merged lane keeps its old slot
    p_merge_keep_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid_i && kmask_en_i && !kmask_i[j] && !zero_mode_i && active[j])
      |=> dst_o[j*INT_W +: INT_W] == $past(old_dst_i[j*INT_W +: INT_W]));

    // R6: zeroed lane is cleared
    p_zero_lane_r6: assert property (@(posedge clk) disable iff (rst)
      (in_valid_i && kmask_en_i && !kmask_i[j] && zero_mode_i)
      |=> dst_o[j*INT_W +: INT_W] == '0);

    // R9: lanes beyond the vector length are cleared
    p_above_vl_r9: assert property (@(posedge clk) disable iff (rst)
      (in_valid_i && !active[j]) |=> dst_o[j*INT_W +: INT_W] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_o       <= '0;
      flag_inv_o  <= 1'b0;
      flag_inx_o  <= 1'b0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        dst_o      <= next_dst;
        flag_inv_o <= flag_inv_o | (|lane_inv);
        flag_inx_o <= flag_inx_o | (|lane_inx);
      end
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> $stable(dst_o) && !out_valid_o);

  p_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> out_valid_o);

  p_sticky_inv_r10: assert property (@(posedge clk) disable iff (rst)
    flag_inv_o |=> flag_inv_o);

  p_sticky_inx_r10: assert property (@(posedge clk) disable iff (rst)
    flag_inx_o |=> flag_inx_o);
endmodule

// File: tb/sim_f2u_vec.sv
module sim_f2u_vec;
  localparam int CLK_PERIOD = 10;
  localparam int L = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [L*32-1:0] src = '0;
  logic           bcast = 1'b0;
  logic [1:0]     vl_sel = 2'd2;
  logic           kmask_en = 1'b0;
  logic [L-1:0]   kmask = '0;
  logic           zero_mode = 1'b0;
  logic [L*64-1:0] old_dst = '0;
  logic [L*64-1:0] dst;
  logic           flag_inv, flag_inx, out_valid;

  logic [31:0] s_in [L];
  logic [63:0] o_in [L];
  logic [63:0] e_out[L];
  int checks = 0;
  int errors = 0;

  localparam logic [31:0] F_ONE  = 32'h3F800000, F_2P5 = 32'h40200000,
                          F_2E63 = 32'h5F000000, F_2E64 = 32'h5F800000,
                          F_MAXB = 32'h5F7FFFFF, F_NAN = 32'h7FC00000,
                          F_PINF = 32'h7F800000, F_NINF = 32'hFF800000,
                          F_NONE = 32'hBF800000, F_NHALF = 32'hBF000000,
                          F_N3P5 = 32'hC0600000, F_DEN = 32'h00000001,
                          F_NZ   = 32'h80000000, F_BIG = 32'h47F12060,
                          F_2E24 = 32'h4B800000, F_0P75 = 32'h3F400000;
  localparam logic [63:0] ONES = '1;

  always #(CLK_PERIOD/2) clk = ~clk;

  f2u_vec u0 (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .src_i(src), .bcast_i(bcast),
    .vl_sel_i(vl_sel), .kmask_en_i(kmask_en), .kmask_i(kmask),
    .zero_mode_i(zero_mode), .old_dst_i(old_dst), .dst_o(dst),
    .flag_inv_o(flag_inv), .flag_inx_o(flag_inx), .out_valid_o(out_valid)
  );

  task automatic chk64(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic fill(input logic [31:0] f);
    for (int j = 0; j < L; j++) begin s_in[j] = f; o_in[j] = 64'hA5A5_0000_0000_0000 | 64'(j); end
  endtask

  task automatic run_op(input logic b, input logic [1:0] vl, input logic men,
                        input logic [L-1:0] km, input logic zm);
    @(negedge clk);
    for (int j = 0; j < L; j++) begin src[j*32 +: 32] = s_in[j]; old_dst[j*64 +: 64] = o_in[j]; end
    bcast = b; vl_sel = vl; kmask_en = men; kmask = km; zero_mode = zm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk_lanes(input string tag);
    for (int j = 0; j < L; j++) chk64($sformatf("%s lane%0d", tag, j), dst[j*64 +: 64], e_out[j]);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk64("R12 dst", dst[63:0] | dst[511:448], 64'h0);
    chk1("R12 inv", flag_inv, 1'b0);
    chk1("R12 inx", flag_inx, 1'b0);
    chk1("R12 valid", out_valid, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_basic();
    do_reset();
    s_in = '{F_ONE, F_2P5, F_2E63, F_MAXB, F_BIG, F_2E24, F_0P75, 32'h0};
    e_out = '{64'd1, 64'd2, 64'h8000000000000000, 64'hFFFFFF0000000000,
              64'd123456, 64'h1000000, 64'd0, 64'd0};
    run_op(1'b0, 2'd2, 1'b0, '0, 1'b0);
    chk_lanes("R1 R2 truncation");
    chk1("R2 inx", flag_inx, 1'b1);
    chk1("R2 inv", flag_inv, 1'b0);
    chk1("R11 valid", out_valid, 1'b1);
  endtask

  task automatic t_invalid();
    do_reset();
    s_in = '{F_NAN, F_PINF, F_NONE, F_2E64, F_NINF, F_N3P5, F_ONE, F_ONE};
    e_out = '{ONES, ONES, ONES, ONES, ONES, ONES, 64'd1, 64'd1};
    run_op(1'b0, 2'd3, 1'b0, '0, 1'b0);
    chk_lanes("R3 invalid");
    chk1("R3 inv", flag_inv, 1'b1);
    chk1("R3 inx", flag_inx, 1'b0);
  endtask

  task automatic t_small();
    do_reset();
    s_in = '{F_NHALF, F_NZ, F_DEN, 32'h0, F_NZ, 32'h0, F_NZ, 32'h0};
    e_out = '{default: 64'd0};
    run_op(1'b0, 2'd2, 1'b0, '0, 1'b0);
    chk_lanes("R4 small");
    chk1("R4 inv", flag_inv, 1'b0);
    chk1("R4 inx", flag_inx, 1'b1);
    do_reset();
    s_in = '{32'h0, F_NZ, 32'h0, F_NZ, 32'h0, F_NZ, 32'h0, F_NZ};
    run_op(1'b0, 2'd2, 1'b0, '0, 1'b0);
    chk_lanes("R4 zeros");
    chk1("R4 zero no inx", flag_inx, 1'b0);
  endtask

  task automatic t_mask(input logic zm);
    do_reset();
    fill(F_ONE);
    for (int j = 1; j < L; j += 2) s_in[j] = F_NAN;
    for (int j = 0; j < L; j++) e_out[j] = (j % 2 == 0) ? 64'd1 : (zm ? 64'd0 : o_in[j]);
    run_op(1'b0, 2'd2, 1'b1, 8'b0101_0101, zm);
    chk_lanes(zm ? "R6 zeroing" : "R5 merging");
    chk1("R10 masked inv", flag_inv, 1'b0);
    chk1("R10 masked inx", flag_inx, 1'b0);
  endtask

  task automatic t_maskoff();
    do_reset();
    fill(F_2P5);
    e_out = '{default: 64'd2};
    run_op(1'b0, 2'd2, 1'b0, 8'h00, 1'b1);
    chk_lanes("R7 mask off");
  endtask

  task automatic t_bcast();
    do_reset();
    fill(F_NAN);
    s_in[0] = F_2P5;
    e_out = '{default: 64'd2};
    run_op(1'b1, 2'd2, 1'b0, '0, 1'b0);
    chk_lanes("R8 broadcast");
    chk1("R8 inv", flag_inv, 1'b0);
    chk1("R8 inx", flag_inx, 1'b1);
  endtask

  task automatic t_vl();
    do_reset();
    fill(F_NAN);
    s_in[0] = F_ONE; s_in[1] = F_2E24;
    e_out = '{64'd1, 64'h1000000, 0, 0, 0, 0, 0, 0};
    run_op(1'b0, 2'd0, 1'b0, '0, 1'b0);
    chk_lanes("R9 R1 vl128");
    chk1("R10 inactive inv", flag_inv, 1'b0);
    fill(F_NAN);
    s_in[0] = F_ONE; s_in[1] = F_ONE; s_in[2] = F_ONE; s_in[3] = F_2P5;
    e_out = '{64'd1, 64'd1, 64'd1, 64'd2, 0, 0, 0, 0};
    run_op(1'b0, 2'd1, 1'b1, 8'h0F, 1'b0);
    chk_lanes("R9 R1 vl256");
    chk1("R10 vl256 inv", flag_inv, 1'b0);
  endtask

  task automatic t_sticky();
    do_reset();
    fill(F_ONE); s_in[4] = F_NAN;
    run_op(1'b0, 2'd2, 1'b0, '0, 1'b0);
    chk1("R10 set inv", flag_inv, 1'b1);
    fill(F_ONE);
    e_out = '{default: 64'd1};
    run_op(1'b0, 2'd2, 1'b0, '0, 1'b0);
    chk1("R10 sticky inv", flag_inv, 1'b1);
    chk_lanes("R11 second op");
    fill(F_2P5);
    @(negedge clk);
    for (int j = 0; j < L; j++) src[j*32 +: 32] = s_in[j];
    repeat (3) @(negedge clk);
    chk_lanes("R11 hold");
    chk1("R11 idle valid", out_valid, 1'b0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_invalid();
    t_small();
    t_mask(1'b0);
    t_mask(1'b1);
    t_maskoff();
    t_bcast();
    t_vl();
    t_sticky();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule